// File: doc/BRIEF.md
# Interleaving Word Selector with Held Blanking

This block sits at the digital front of a segmented converter. Two data words arrive on separate buses, and a select line picks one of them on each falling clock edge. Two half-rate streams can therefore be merged into one full-rate code stream. The chosen word is registered together with a single internal blank bit, and the converter core consumes both.

A blanking request overrides the data. The request is looked at only on edges where word A is picked. On edges where word B is picked, the request last seen while A was picked stays in force, so one slow control stream can cover both interleaved data streams. If the select line stays low after a blanking request has been latched, the latched request is never cleared. A status flag reports this lockup-prone condition once it has lasted longer than a programmable number of edges.

Top module: `dual_word_blank_mux`

## Requirements
- R1: On a falling edge with `sel_a`=1 and `blank_req`=0, `code_out` takes `word_a` and `blank_out` becomes 0.
- R2: On a falling edge with `sel_a`=0 and the held request at 0, `code_out` takes `word_b` and `blank_out` becomes 0.
- R3: On a falling edge with `sel_a`=1 and `blank_req`=1, `code_out` becomes all ones and `blank_out` becomes 1. That edge also loads the held request with the sampled `blank_req`.
- R4: While `sel_a`=0, `blank_req` is ignored. Each such edge applies the request that was sampled on the last edge with `sel_a`=1.
- R5: If the held request is 1 and `sel_a` stays 0, every edge keeps `code_out` all ones and `blank_out` 1. Only an edge with `sel_a`=1 and `blank_req`=0 clears it.
- R6: A falling edge with `rst`=1 clears `code_out`, `blank_out`, `stall_flag` and the held request to 0.
- R7: `stall_flag` rises on the edge that completes more than `STALL_LIMIT` consecutive edges with `sel_a`=0 and the held request at 1. It falls on the first edge where that condition is broken.
- R8: Outputs change only on falling clock edges. Input changes between falling edges leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| word_a | input | DATA_W | Data word picked when `sel_a`=1 |
| word_b | input | DATA_W | Data word picked when `sel_a`=0 |
| sel_a | input | 1 | Word select, 1 picks A and 0 picks B |
| blank_req | input | 1 | Blanking request, sampled only when `sel_a`=1 |
| code_out | output | DATA_W | Registered code for the converter core |
| blank_out | output | 1 | Registered internal blank bit |
| stall_flag | output | 1 | Lockup-prone condition has persisted |

## Verification
The bench builds the block with `DATA_W`=8 and `STALL_LIMIT`=4. The short limit lets the stall flag rise, hold and clear within a few edges. It also lets the counter reach its saturation value during one stretch of blanked B-only operation. A behavioural model of the held request is compared with the outputs after every falling edge. The outputs are also checked once more between edges, after the inputs have been changed.

// File: rtl/dwb_pkg.sv
package dwb_pkg;
    typedef enum logic {
        PICK_B = 1'b0,
        PICK_A = 1'b1
    } pick_e;
endpackage

// File: rtl/dwb_blank_hold.sv
module dwb_blank_hold (
    input  logic clk,
    input  logic rst,
    input  logic sel_a,
    input  logic blank_req,
    output logic eff_blank,
    output logic held_q
);
    typedef struct packed {
        logic held;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        eff_blank = st_q.held;
        if (sel_a) begin
            eff_blank  = blank_req;
            st_d.held  = blank_req;
        end
        if (rst) begin
            st_d.held = 1'b0;
        end
    end

    always_ff @(negedge clk) begin
        st_q <= st_d;
    end

    assign held_q = st_q.held;
endmodule

// File: rtl/dwb_word_pick.sv
module dwb_word_pick #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] word_a,
    input  logic [DATA_W-1:0] word_b,
    input  logic              sel_a,
    input  logic              eff_blank,
    output logic [DATA_W-1:0] code_q,
    output logic              blank_q
);
    import dwb_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] code;
        logic              blank;
    } out_t;

    out_t  st_d, st_q;
    pick_e pick;

    always_comb begin
        pick       = pick_e'(sel_a);
        st_d.code  = (pick == PICK_A) ? word_a : word_b;
        st_d.blank = eff_blank;
        if (eff_blank) begin
            st_d.code = '1;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(negedge clk) begin
        st_q <= st_d;
    end

    assign code_q  = st_q.code;
    assign blank_q = st_q.blank;
endmodule

// File: rtl/dwb_stall_mon.sv
module dwb_stall_mon #(
    parameter int STALL_LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_a,
    input  logic held,
    output logic flag_q
);
    localparam int CNT_W = $clog2(STALL_LIMIT + 2);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(STALL_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(STALL_LIMIT);

    typedef struct packed {
        logic [CNT_W-1:0] run;
        logic             flag;
    } mon_t;

    mon_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!sel_a && held) begin
            if (st_q.run != SAT) begin
                st_d.run = st_q.run + 1'b1;
            end
        end else begin
            st_d.run = '0;
        end
        st_d.flag = (st_d.run > LIM);
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(negedge clk) begin
        st_q <= st_d;
    end

    assign flag_q = st_q.flag;
endmodule

// File: rtl/dual_word_blank_mux.sv
module dual_word_blank_mux #(
    parameter int DATA_W      = 8,
    parameter int STALL_LIMIT = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] word_a,
    input  logic [DATA_W-1:0] word_b,
    input  logic              sel_a,
    input  logic              blank_req,
    output logic [DATA_W-1:0] code_out,
    output logic              blank_out,
    output logic              stall_flag
);
    logic eff_blank;
    logic held_q;

    dwb_blank_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .sel_a     (sel_a),
        .blank_req (blank_req),
        .eff_blank (eff_blank),
        .held_q    (held_q)
    );

    dwb_word_pick #(.DATA_W(DATA_W)) u_pick (
        .clk       (clk),
        .rst       (rst),
        .word_a    (word_a),
        .word_b    (word_b),
        .sel_a     (sel_a),
        .eff_blank (eff_blank),
        .code_q    (code_out),
        .blank_q   (blank_out)
    );

    dwb_stall_mon #(.STALL_LIMIT(STALL_LIMIT)) u_mon (
        .clk    (clk),
        .rst    (rst),
        .sel_a  (sel_a),
        .held   (held_q),
        .flag_q (stall_flag)
    );
endmodule

// File: rtl/dwb_checker.sv
module dwb_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] word_a,
    input logic [DATA_W-1:0] word_b,
    input logic              sel_a,
    input logic              blank_req,
    input logic              held,
    input logic [DATA_W-1:0] code_out,
    input logic              blank_out,
    input logic              stall_flag
);
    AST_A_PASSES: assert property (@(negedge clk) disable iff (rst)
        (sel_a && !blank_req) |=> (code_out == $past(word_a) && !blank_out)); // R1

    AST_B_PASSES: assert property (@(negedge clk) disable iff (rst)
        (!sel_a && !held) |=> (code_out == $past(word_b) && !blank_out)); // R2

    AST_BLANK_FORCES: assert property (@(negedge clk) disable iff (rst)
        (sel_a && blank_req) |=> (blank_out && (&code_out))); // R3

    AST_B_USES_HELD: assert property (@(negedge clk) disable iff (rst)
        !sel_a |=> (blank_out == $past(held))); // R4

    AST_LOCK_STAYS: assert property (@(negedge clk) disable iff (rst)
        (!sel_a && held) |=> (blank_out && held)); // R5

    AST_RESET_CLEARS: assert property (@(negedge clk)
        rst |=> (code_out == '0 && !blank_out && !stall_flag && !held)); // R6

    AST_FLAG_BLANKED: assert property (@(negedge clk) disable iff (rst)
        stall_flag |-> blank_out); // R7

    AST_FLAG_DROPS: assert property (@(negedge clk) disable iff (rst)
        sel_a |=> !stall_flag); // R7
endmodule

bind dual_word_blank_mux dwb_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .word_a     (word_a),
    .word_b     (word_b),
    .sel_a      (sel_a),
    .blank_req  (blank_req),
    .held       (held_q),
    .code_out   (code_out),
    .blank_out  (blank_out),
    .stall_flag (stall_flag)
);

// File: tb/test_dual_word_blank_mux.sv
module test_dual_word_blank_mux;
    localparam int PERIOD = 10;
    localparam int W      = 8;
    localparam int LIMIT  = 4;

    logic         clk = 1'b1;
    logic         rst = 1'b1;
    logic [W-1:0] word_a = '0;
    logic [W-1:0] word_b = '0;
    logic         sel_a = 1'b0;
    logic         blank_req = 1'b0;
    logic [W-1:0] code_out;
    logic         blank_out;
    logic         stall_flag;

    int total = 0;
    int bad   = 0;

    // behavioural model state
    int m_code  = 0;
    int m_blank = 0;
    int m_hold  = 0;
    int m_run   = 0;
    int m_flag  = 0;

    always #(PERIOD/2) clk = ~clk;

    dual_word_blank_mux #(.DATA_W(W), .STALL_LIMIT(LIMIT)) i_dual_word_blank_mux (
        .clk        (clk),
        .rst        (rst),
        .word_a     (word_a),
        .word_b     (word_b),
        .sel_a      (sel_a),
        .blank_req  (blank_req),
        .code_out   (code_out),
        .blank_out  (blank_out),
        .stall_flag (stall_flag)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_edge(input int r, input int a, input int b, input int s, input int bl);
        int eff;
        if (r != 0) begin
            m_code = 0; m_blank = 0; m_hold = 0; m_run = 0; m_flag = 0;
        end else begin
            eff = (s != 0) ? bl : m_hold;
            if (s == 0 && m_hold != 0) m_run = (m_run < LIMIT + 1) ? m_run + 1 : m_run;
            else m_run = 0;
            m_flag  = (m_run > LIMIT) ? 1 : 0;
            m_code  = (eff != 0) ? 255 : ((s != 0) ? a : b);
            m_blank = eff;
            if (s != 0) m_hold = bl;
        end
    endtask

    task automatic step(input int r, input int a, input int b, input int s, input int bl,
                        input string tag);
        @(posedge clk);
        rst = r[0]; word_a = a[W-1:0]; word_b = b[W-1:0]; sel_a = s[0]; blank_req = bl[0];
        #1;
        check("R8", "code between edges", int'(code_out), m_code);
        check("R8", "blank between edges", int'(blank_out), m_blank);
        @(negedge clk);
        model_edge(r, a, b, s, bl);
        #1;
        check(tag, "code", int'(code_out), m_code);
        check(tag, "blank", int'(blank_out), m_blank);
        check((r != 0) ? "R6" : "R7", "stall flag", int'(stall_flag), m_flag);
    endtask

    initial begin
        #(PERIOD * 5000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(1, 8'h11, 8'h22, 1, 1, "R6");
        step(1, 8'h33, 8'h44, 0, 1, "R6");
        // word A alone
        step(0, 8'h5A, 8'hC3, 1, 0, "R1");
        step(0, 8'h00, 8'hFF, 1, 0, "R1");
        step(0, 8'hFE, 8'h01, 1, 0, "R1");
        // word B with held low
        step(0, 8'h12, 8'h81, 0, 0, "R2");
        step(0, 8'h34, 8'h7F, 0, 0, "R2");
        // interleaved
        for (int i = 0; i < 6; i++) begin
            step(0, 16 * i + 3, 200 - 7 * i, (i % 2 == 0) ? 1 : 0, 0, (i % 2 == 0) ? "R1" : "R2");
        end
        // blank while A picked, then carried through B
        step(0, 8'h10, 8'h20, 1, 1, "R3");
        step(0, 8'h10, 8'h20, 0, 0, "R4");
        step(0, 8'h11, 8'h21, 1, 0, "R3");
        // request ignored while B picked with held low
        step(0, 8'h66, 8'h99, 0, 1, "R4");
        step(0, 8'h67, 8'h98, 0, 1, "R4");
        // lockup and stall flag
        step(0, 8'h01, 8'h02, 1, 1, "R3");
        for (int i = 0; i < 8; i++) begin
            step(0, i, 50 + i, 0, i % 2, "R5");
        end
        step(0, 8'hA0, 8'hB0, 1, 0, "R5");
        step(0, 8'hA1, 8'hB1, 0, 0, "R2");
        // flag runs up, then a brief A edge with blank still high
        step(0, 8'h01, 8'h02, 1, 1, "R3");
        for (int i = 0; i < 6; i++) begin
            step(0, i, 90 + i, 0, 0, "R7");
        end
        step(0, 8'h05, 8'h06, 1, 1, "R7");
        step(0, 8'h05, 8'h06, 0, 0, "R7");
        // reset while held high, then B must pass
        step(1, 8'h00, 8'h00, 0, 0, "R6");
        step(0, 8'h3C, 8'hC3, 0, 1, "R6");
        step(0, 8'h3C, 8'hC3, 0, 0, "R2");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule